// File: doc/BRIEF.md
# Two-Line Primary Interrupt Aggregator

This block is the first stage of a two-stage interrupt tree. Up to eight secondary interrupt modules each raise a pending request toward two host masters. The aggregator collects these requests separately for each master. It registers them into one primary status register per master and drives one active-low interrupt pin per master. Each status bit names the secondary module that wants service, so a master can read its status register to find out which module to visit.

The primary stage has no mask of its own: masking is done inside the secondary modules. Slots whose module is absent are tied off by a parameter, and their bits always read as zero. A small register port carries reads and writes. It returns either status register and gives access to a test register. Writing ones to the test register injects requests into both lines at once, so the whole interrupt path can be exercised without the secondary modules.

Top module: `irq_primary_agg`

## Requirements
- R1: Bit n of line k's status register (read at offset 0x01 for line 0, 0x02 for line 1) holds secondary module n's request on line k, with module 0 in bit 0. A request present before a clock edge is in the register after that edge.
- R2: The two lines are independent. A request on one line's input never shows in the other line's status or pin.
- R3: There is no primary masking. Every asserted request of a populated slot appears in its status bit.
- R4: The pins `irq_line0_n_o` and `irq_line1_n_o` are low exactly when their line's registered status is nonzero, and they change on the same edge as the status.
- R5: A read strobe captures the addressed register into `reg_rdata_o` on the next edge. Without a strobe, `reg_rdata_o` holds its value.
- R6: The test register lives at offset 0x03 and reads back its value. A write stores the data on the next edge. From the edge after that, each 1 bit forces the matching status bit on both lines and 0 bits release the force.
- R7: Writes to offsets 0x01, 0x02 and any other offset except 0x03 change nothing.
- R8: A read of any offset other than 0x01, 0x02 or 0x03 returns zero.
- R9: Slots cleared in the population mask (default 0x3F, slots 6 and 7 absent) read zero in both status registers and in the test register, and never pull a pin low.
- R10: After reset both status registers, the test register and the read data are zero, and both pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line0_req_i | input | 8 | Per-module requests toward master 0 |
| line1_req_i | input | 8 | Per-module requests toward master 1 |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_line0_n_o | output | 1 | Active-low interrupt to master 0 |
| irq_line1_n_o | output | 1 | Active-low interrupt to master 1 |

## Verification
A wrong status register shows one edge later in two ways: as a pin at the wrong level, and as wrong read data on the next read of that line. A test register that stored, dropped or leaked a bit shows on both pins one edge after the write. It also shows on a read of offset 0x03. A decoding slip that let a status offset take a write shows as a changed test read-back. Crossed lines show as a pin that follows the other master's requests within a single cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned DEF_SLOTS    = 8;
    localparam int unsigned DEF_LINES    = 2;
    localparam int unsigned DEF_ADDR_W   = 8;
    // first line status offset; lines follow, test register after the last line
    localparam int unsigned LINE_OFS_BASE = 1;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LINE  = 2'd1,
        ACC_TEST  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/irq_line_collect.sv
module irq_line_collect #(
    parameter int unsigned           NUM_SLOTS = 8,
    parameter logic [NUM_SLOTS-1:0]  SLOT_POP  = 8'h3F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req_i,
    input  logic [NUM_SLOTS-1:0] force_i,
    output logic [NUM_SLOTS-1:0] status_o,
    output logic                 irq_n_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] status;
        logic                 irq_n;
    } line_state_t;

    line_state_t st_d, st_q;
    logic [NUM_SLOTS-1:0] gathered;

    always_comb begin
        gathered     = (req_i | force_i) & SLOT_POP;
        st_d         = st_q;
        st_d.status  = gathered;
        st_d.irq_n   = ~(|gathered);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.irq_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_n_o  = st_q.irq_n;

    AST_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_i) & SLOT_POP & ~status_o) == '0)); // R3
    AST_REQ_LOWERS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & SLOT_POP) != '0) |=> !irq_n_o); // R4
    AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (((req_i | force_i) & SLOT_POP) == '0) |=> irq_n_o); // R4
endmodule

// File: rtl/irq_test_reg.sv
module irq_test_reg #(
    parameter int unsigned           NUM_SLOTS = 8,
    parameter logic [NUM_SLOTS-1:0]  SLOT_POP  = 8'h3F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [NUM_SLOTS-1:0] wdata_i,
    output logic [NUM_SLOTS-1:0] test_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] force_bits;
    } test_state_t;

    test_state_t ts_d, ts_q;

    always_comb begin
        ts_d = ts_q;
        if (wr_en_i) begin
            ts_d.force_bits = wdata_i & SLOT_POP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign test_o = ts_q.force_bits;

    AST_TEST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (test_o == ($past(wdata_i) & SLOT_POP))); // R6
    AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(test_o)); // R7
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned NUM_LINES = 2,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           wr_i,
    input  logic                           rd_i,
    input  logic [NUM_LINES*NUM_SLOTS-1:0] status_i,
    input  logic [NUM_SLOTS-1:0]           test_i,
    output logic                           test_wr_o,
    output logic [NUM_SLOTS-1:0]           rdata_o
);
    localparam int unsigned TEST_OFS = LINE_OFS_BASE + NUM_LINES;
    localparam int unsigned LINE_IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] rdata;
    } port_state_t;

    port_state_t ps_d, ps_q;
    acc_kind_e             kind;
    logic [LINE_IDX_W-1:0] line_idx;
    logic [NUM_SLOTS-1:0]  line_word [NUM_LINES];

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_split
            assign line_word[g] = status_i[g*NUM_SLOTS +: NUM_SLOTS];
        end
    endgenerate

    always_comb begin
        kind     = ACC_NONE;
        line_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (addr_i == ADDR_W'(LINE_OFS_BASE + i)) begin
                kind     = ACC_LINE;
                line_idx = LINE_IDX_W'(i);
            end
        end
        if (addr_i == ADDR_W'(TEST_OFS)) begin
            kind = ACC_TEST;
        end
    end

    always_comb begin
        ps_d = ps_q;
        if (rd_i) begin
            unique case (kind)
                ACC_LINE: ps_d.rdata = line_word[line_idx];
                ACC_TEST: ps_d.rdata = test_i;
                default:  ps_d.rdata = '0;
            endcase
        end
    end

    assign test_wr_o = wr_i && (kind == ACC_TEST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign rdata_o = ps_q.rdata;

    AST_UNKNOWN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (kind == ACC_NONE)) |=> (rdata_o == '0)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o)); // R5
endmodule

// File: rtl/irq_primary_agg.sv
module irq_primary_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned           NUM_SLOTS = DEF_SLOTS,
    parameter int unsigned           ADDR_W    = DEF_ADDR_W,
    parameter logic [NUM_SLOTS-1:0]  SLOT_POP  = 8'h3F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] line0_req_i,
    input  logic [NUM_SLOTS-1:0] line1_req_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [NUM_SLOTS-1:0] reg_wdata_i,
    output logic [NUM_SLOTS-1:0] reg_rdata_o,
    output logic                 irq_line0_n_o,
    output logic                 irq_line1_n_o
);
    localparam int unsigned NUM_LINES = DEF_LINES;

    logic [NUM_SLOTS-1:0]           req_vec  [NUM_LINES];
    logic [NUM_LINES*NUM_SLOTS-1:0] status_flat;
    logic [NUM_LINES-1:0]           pin_n;
    logic [NUM_SLOTS-1:0]           test_bits;
    logic                           test_wr;

    assign req_vec[0] = line0_req_i;
    assign req_vec[1] = line1_req_i;

    genvar l;
    generate
        for (l = 0; l < NUM_LINES; l++) begin : g_line
            irq_line_collect #(
                .NUM_SLOTS (NUM_SLOTS),
                .SLOT_POP  (SLOT_POP)
            ) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .req_i    (req_vec[l]),
                .force_i  (test_bits),
                .status_o (status_flat[l*NUM_SLOTS +: NUM_SLOTS]),
                .irq_n_o  (pin_n[l])
            );
        end
    endgenerate

    irq_test_reg #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_POP  (SLOT_POP)
    ) u_test (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (test_wr),
        .wdata_i (reg_wdata_i),
        .test_o  (test_bits)
    );

    irq_reg_port #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .status_i  (status_flat),
        .test_i    (test_bits),
        .test_wr_o (test_wr),
        .rdata_o   (reg_rdata_o)
    );

    assign irq_line0_n_o = pin_n[0];
    assign irq_line1_n_o = pin_n[1];

    AST_UNPOP_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flat & {NUM_LINES{~SLOT_POP}}) == '0)); // R9
    AST_LINE_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        ((line0_req_i == '0) && (test_bits == '0)) |=> irq_line0_n_o); // R2
endmodule

// File: tb/tb_irq_primary_agg.sv
module tb_irq_primary_agg;
    localparam logic [7:0] POP = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req0 = '0, req1 = '0, addr = '0, wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       pin0_n, pin1_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_stat0 = '0, m_stat1 = '0, m_test = '0, m_rdata = '0;

    always #10 clk = ~clk;

    irq_primary_agg dut (
        .clk(clk), .rst_n(rst_n),
        .line0_req_i(req0), .line1_req_i(req1),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_line0_n_o(pin0_n), .irq_line1_n_o(pin1_n)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] read_model(input logic [7:0] a, input logic [7:0] s0,
                                              input logic [7:0] s1, input logic [7:0] t);
        case (a)
            8'h01:   return s0;
            8'h02:   return s1;
            8'h03:   return t;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h01, 8'h02: return "R1/R5 status read";
            8'h03:        return "R6 test read-back";
            default:      return "R8 unknown offset";
        endcase
    endfunction

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] a,
                       input logic w, input logic r, input logic [7:0] d);
        logic [7:0] n0, n1, nt;
        req0 = r0; req1 = r1; addr = a; wr = w; rd = r; wdata = d;
        @(posedge clk);
        if (r) m_rdata = read_model(a, m_stat0, m_stat1, m_test);
        n0 = (r0 | m_test) & POP;
        n1 = (r1 | m_test) & POP;
        nt = (w && a == 8'h03) ? (d & POP) : m_test;
        m_stat0 = n0; m_stat1 = n1; m_test = nt;
        @(negedge clk);
        check(pin0_n == ~|m_stat0, "R4/R2/R3 line0 pin", {7'd0, pin0_n}, {7'd0, ~|m_stat0});
        check(pin1_n == ~|m_stat1, "R4/R2/R3 line1 pin", {7'd0, pin1_n}, {7'd0, ~|m_stat1});
        if (r) check(rdata == m_rdata, read_tag(a), rdata, m_rdata);
        else   check(rdata == m_rdata, "R5 rdata hold", rdata, m_rdata);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=00 expected=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check(pin0_n === 1'b1 && pin1_n === 1'b1, "R10 pins high in reset", {6'd0, pin1_n, pin0_n}, 8'h03);
        check(rdata === 8'h00, "R10 rdata zero in reset", rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(0, 0, 8'h01, 0, 1, 0);
        cyc(0, 0, 8'h03, 0, 1, 0);
        check(rdata == 8'h00, "R10 test reg zero after reset", rdata, 8'h00);

        // R1 bit order: module 0 on line 0 only, then read
        cyc(8'h01, 0, 8'h00, 0, 0, 0);
        cyc(8'h01, 0, 8'h01, 0, 1, 0);
        cyc(8'h01, 0, 8'h01, 0, 1, 0);
        check(rdata == 8'h01, "R1 module0 in bit0", rdata, 8'h01);
        cyc(8'h01, 0, 8'h02, 0, 1, 0);
        check(rdata == 8'h00, "R2 line1 unaffected by line0", rdata, 8'h00);
        check(pin1_n == 1'b1, "R2 line1 pin stays high", {7'd0, pin1_n}, 8'h01);

        // R9 unpopulated slots
        cyc(8'hFF, 8'hC0, 8'h01, 0, 1, 0);
        cyc(8'hFF, 8'hC0, 8'h01, 0, 1, 0);
        check(rdata == 8'h3F, "R9 slots 6,7 read zero", rdata, 8'h3F);
        check(pin1_n == 1'b1, "R9 unpopulated request leaves pin high", {7'd0, pin1_n}, 8'h01);

        // R6 test force on both lines, R9 on test bits
        cyc(0, 0, 8'h03, 1, 0, 8'hC4);
        cyc(0, 0, 8'h02, 0, 1, 0);
        cyc(0, 0, 8'h03, 0, 1, 0);
        check(rdata == 8'h04, "R6/R9 test register masked read-back", rdata, 8'h04);
        check(pin0_n == 1'b0 && pin1_n == 1'b0, "R6 force lowers both pins", {6'd0, pin1_n, pin0_n}, 8'h00);

        // R7 writes to status and unknown offsets ignored
        cyc(0, 0, 8'h01, 1, 0, 8'h00);
        cyc(0, 0, 8'h02, 1, 0, 8'h00);
        cyc(0, 0, 8'h7E, 1, 0, 8'h00);
        cyc(0, 0, 8'h03, 0, 1, 0);
        check(rdata == 8'h04, "R7 test reg unchanged by other writes", rdata, 8'h04);
        cyc(0, 0, 8'h01, 0, 1, 0);
        check(rdata == 8'h04, "R7 status keeps forced bit", rdata, 8'h04);

        // R6 release
        cyc(0, 0, 8'h03, 1, 0, 8'h00);
        cyc(0, 0, 8'h00, 0, 0, 0);
        check(pin0_n == 1'b1 && pin1_n == 1'b1, "R6 release raises pins", {6'd0, pin1_n, pin0_n}, 8'h03);

        // R8 unknown offsets
        cyc(8'h3F, 8'h3F, 8'h00, 0, 1, 0);
        check(rdata == 8'h00, "R8 offset 0x00 reads zero", rdata, 8'h00);
        cyc(8'h3F, 8'h3F, 8'hFF, 0, 1, 0);
        check(rdata == 8'h00, "R8 offset 0xFF reads zero", rdata, 8'h00);

        // random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a;
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 7));
            case (sel)
                3'd0: a = 8'h00;
                3'd1, 3'd2: a = 8'h01;
                3'd3: a = 8'h02;
                3'd4, 3'd5: a = 8'h03;
                default: a = 8'($urandom);
            endcase
            cyc(8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom), a,
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 1) == 0), 8'($urandom) & 8'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule